// File: doc/BRIEF.md
# Flash command sequence decoder

This block watches the write cycles arriving on the device side of a parallel NOR-style flash bus. Each write presents an address, a 16-bit data word and a flag saying whether the bus runs in byte or word addressing. From these writes the block picks out keyed multi-cycle command sequences and keeps track of which mode the device is in. It then issues single-clock request pulses to the program and erase engines that sit downstream.

A program request comes with the captured target address and data. A sector erase request comes with the sector number. Chip erase, erase suspend and erase resume have pulses of their own. The block has no memory array, no embedded algorithms and no status polling. An external busy input tells it when an erase is running, so that a suspend command can be honoured. The current mode and an erase-suspended flag are exposed for the read path to use.

Top module: `flash_cmd_decoder`

## Requirements
- R1: While `rst_ni` is low, and on the first cycles after it rises, `mode_o` is 0 (array read), `suspended_o` is 0 and every request output is 0. An asynchronous reset discards any partial sequence.
- R2: In word mode, data AA at address 555 followed by 55 at 2AA forms the unlock key. In byte mode the same two writes use addresses AAA and 555. A third write of 90 at the first key address sets `mode_o` to 1 (autoselect).
- R3: After the unlock key, data A0 at the first key address arms a program. The next write raises `prog_req_o` for one cycle. The same edge loads `prog_addr_o` and `prog_data_o` with that write's full address and data.
- R4: Unlock key, 80, unlock key, then 10 at the first key address raises `chip_erase_o` for one cycle.
- R5: Unlock key, 80, unlock key, then 30 at any address raises `sector_erase_o` for one cycle. `sector_o` is loaded from address bits 18..12 in word mode, or bits 19..13 in byte mode, and it changes at no other time.
- R6: In autoselect mode only the return command has any effect, apart from the suspend and resume commands. The return command is F0 written at any address, and it sets `mode_o` to 0.
- R7: Unlock key followed by 20 sets `mode_o` to 2 (bypass). In bypass mode, A0 at any address followed by one data write raises `prog_req_o` with that address and data.
- R8: In bypass mode, 90 at any address followed by 00 at any address sets `mode_o` back to 0.
- R9: B0 at any address raises `suspend_o` and sets `suspended_o`, but only while `erase_busy_i` is 1 and no erase is suspended. 30 raises `resume_o` and clears `suspended_o`, but only while an erase is suspended. In every other case these commands are ignored.
- R10: While `suspended_o` is 1, program sequences and autoselect entry are accepted. Erase setup (80) and bypass entry (20) are rejected.
- R11: A write that does not match the expected next cycle of a sequence drops the partial sequence. It leaves the mode unchanged, raises no request, and never changes `mode_o` except as these requirements state.
- R12: In unlock and command cycles, data bits 15..8 are ignored. Address bits above bit 10 (word mode) or above bit 11 (byte mode) are also ignored.
- R13: Each request output is high for exactly one clock after the write that completes its sequence. At most one request is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_valid_i | input | 1 | One-cycle write strobe |
| wr_addr_i | input | 20 | Write address (byte address in byte mode) |
| wr_data_i | input | 16 | Write data |
| byte_mode_i | input | 1 | 1 selects byte addressing keys |
| erase_busy_i | input | 1 | An erase is currently running |
| mode_o | output | 2 | 0 array read, 1 autoselect, 2 bypass |
| suspended_o | output | 1 | An erase is suspended |
| prog_req_o | output | 1 | Program request pulse |
| prog_addr_o | output | 20 | Captured program address |
| prog_data_o | output | 16 | Captured program data |
| chip_erase_o | output | 1 | Chip erase request pulse |
| sector_erase_o | output | 1 | Sector erase request pulse |
| sector_o | output | 7 | Captured sector number |
| suspend_o | output | 1 | Erase suspend pulse |
| resume_o | output | 1 | Erase resume pulse |

## Verification
The assertions check a set of properties on every cycle. Requests are exclusive and last one cycle. Every request and every mode change follows a write. Suspend and resume agree with the suspended flag, erase requests never appear while suspended, and the captured sector and program fields move only together with their pulses. What the assertions cannot tell is whether a given write sequence was decoded correctly. The bench has to show that by walking concrete sequences: byte and word keys, masked high data and address bits, mismatched cycles that must die silently, and the suspended-state rules for erase setup and bypass entry.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef enum logic [1:0] {
    MODE_READ    = 2'd0,
    MODE_AUTOSEL = 2'd1,
    MODE_BYPASS  = 2'd2
  } mode_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_UNL1,
    ST_UNL2,
    ST_PGM,
    ST_ERS1,
    ST_ERS2,
    ST_ERS3,
    ST_BYP_PGM,
    ST_BYP_EXIT
  } step_e;

  // word-mode key addresses; byte-mode keys append one LSB
  localparam logic [10:0] KEY_A_WORD = 11'h555;
  localparam logic [10:0] KEY_B_WORD = 11'h2AA;
  localparam int unsigned KEY_W      = $bits(KEY_A_WORD);

  localparam logic [7:0] CODE_UNLOCK_A = 8'hAA;
  localparam logic [7:0] CODE_UNLOCK_B = 8'h55;
  localparam logic [7:0] CODE_AUTOSEL  = 8'h90;
  localparam logic [7:0] CODE_PROGRAM  = 8'hA0;
  localparam logic [7:0] CODE_ERASE    = 8'h80;
  localparam logic [7:0] CODE_BYPASS   = 8'h20;
  localparam logic [7:0] CODE_CHIP     = 8'h10;
  localparam logic [7:0] CODE_SECTOR   = 8'h30;
  localparam logic [7:0] CODE_RESUME   = 8'h30;
  localparam logic [7:0] CODE_SUSPEND  = 8'hB0;
  localparam logic [7:0] CODE_RESET    = 8'hF0;
  localparam logic [7:0] CODE_BYP_EXIT = 8'h00;
endpackage

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
  import flash_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W   = 20,
  parameter int unsigned SECT_LSB = 12,
  parameter int unsigned SECT_W   = 7
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        code_i,
  input  logic              byte_mode_i,
  output logic              key_a_o,
  output logic              key_b_o,
  output logic [7:0]        code_o,
  output logic [SECT_W-1:0] sector_o
);
  localparam int unsigned BKEY_W   = KEY_W + 1;
  localparam int unsigned SECT_MSB = SECT_LSB + SECT_W - 1;

  logic [KEY_W-1:0]  wkey;
  logic [BKEY_W-1:0] bkey;
  logic [SECT_W-1:0] sect_word;
  logic [SECT_W-1:0] sect_byte;

  assign wkey   = addr_i[KEY_W-1:0];
  assign bkey   = addr_i[BKEY_W-1:0];
  assign code_o = code_i;

  always_comb begin
    if (byte_mode_i) begin
      key_a_o = (bkey == {KEY_A_WORD, 1'b0});
      key_b_o = (bkey == {KEY_B_WORD, 1'b1});
    end else begin
      key_a_o = (wkey == KEY_A_WORD);
      key_b_o = (wkey == KEY_B_WORD);
    end
  end

  // sector field sits one bit higher in byte addressing
  generate
    if (ADDR_W > SECT_MSB + 1) begin : g_byte_sect
      assign sect_byte = addr_i[SECT_MSB+1:SECT_LSB+1];
    end else begin : g_byte_sect_short
      assign sect_byte = {1'b0, addr_i[ADDR_W-1:SECT_LSB+1]};
    end
  endgenerate

  assign sect_word = addr_i[SECT_MSB:SECT_LSB];
  assign sector_o  = byte_mode_i ? sect_byte : sect_word;
endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import flash_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned SECT_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              erase_busy_i,
  input  logic              key_a_i,
  input  logic              key_b_i,
  input  logic [7:0]        code_i,
  input  logic [SECT_W-1:0] sector_i,
  output logic [1:0]        mode_o,
  output logic              suspended_o,
  output logic              prog_req_o,
  output logic [ADDR_W-1:0] prog_addr_o,
  output logic [DATA_W-1:0] prog_data_o,
  output logic              chip_erase_o,
  output logic              sector_erase_o,
  output logic [SECT_W-1:0] sector_o,
  output logic              suspend_o,
  output logic              resume_o
);
  step_e step_q, step_d;
  mode_e mode_q, mode_d;
  logic  susp_q, susp_d;
  logic  pgm_d, chip_d, sect_d, sus_d, res_d, took;
  logic  pgm_q, chip_q, sect_q, sus_q, res_q;
  logic [ADDR_W-1:0] paddr_q;
  logic [DATA_W-1:0] pdata_q;
  logic [SECT_W-1:0] sector_q;

  always_comb begin
    step_d = step_q;
    mode_d = mode_q;
    susp_d = susp_q;
    pgm_d  = 1'b0;
    chip_d = 1'b0;
    sect_d = 1'b0;
    sus_d  = 1'b0;
    res_d  = 1'b0;
    took   = 1'b0;
    if (wr_valid_i) begin
      step_d = ST_IDLE;
      unique case (step_q)
        ST_IDLE: begin
          if (mode_q == MODE_READ && key_a_i && code_i == CODE_UNLOCK_A) begin
            step_d = ST_UNL1;
            took   = 1'b1;
          end else if (mode_q == MODE_BYPASS && code_i == CODE_PROGRAM) begin
            step_d = ST_BYP_PGM;
            took   = 1'b1;
          end else if (mode_q == MODE_BYPASS && code_i == CODE_AUTOSEL) begin
            step_d = ST_BYP_EXIT;
            took   = 1'b1;
          end
        end
        ST_UNL1: begin
          if (key_b_i && code_i == CODE_UNLOCK_B) begin
            step_d = ST_UNL2;
            took   = 1'b1;
          end
        end
        ST_UNL2: begin
          if (key_a_i) begin
            if (code_i == CODE_AUTOSEL) begin
              mode_d = MODE_AUTOSEL;
              took   = 1'b1;
            end else if (code_i == CODE_PROGRAM) begin
              step_d = ST_PGM;
              took   = 1'b1;
            end else if (code_i == CODE_ERASE && !susp_q) begin
              step_d = ST_ERS1;
              took   = 1'b1;
            end else if (code_i == CODE_BYPASS && !susp_q) begin
              mode_d = MODE_BYPASS;
              took   = 1'b1;
            end
          end
        end
        ST_PGM, ST_BYP_PGM: begin
          pgm_d = 1'b1;
          took  = 1'b1;
        end
        ST_ERS1: begin
          if (key_a_i && code_i == CODE_UNLOCK_A) begin
            step_d = ST_ERS2;
            took   = 1'b1;
          end
        end
        ST_ERS2: begin
          if (key_b_i && code_i == CODE_UNLOCK_B) begin
            step_d = ST_ERS3;
            took   = 1'b1;
          end
        end
        ST_ERS3: begin
          if (key_a_i && code_i == CODE_CHIP) begin
            chip_d = 1'b1;
            took   = 1'b1;
          end else if (code_i == CODE_SECTOR) begin
            sect_d = 1'b1;
            took   = 1'b1;
          end
        end
        ST_BYP_EXIT: begin
          if (code_i == CODE_BYP_EXIT) begin
            mode_d = MODE_READ;
            took   = 1'b1;
          end
        end
        default: ;
      endcase
      // single-write commands, honoured outside the data cycle of a program
      if (!took) begin
        if (code_i == CODE_RESET && mode_q != MODE_BYPASS) mode_d = MODE_READ;
        if (code_i == CODE_SUSPEND && erase_busy_i && !susp_q) begin
          sus_d  = 1'b1;
          susp_d = 1'b1;
        end
        if (code_i == CODE_RESUME && susp_q) begin
          res_d  = 1'b1;
          susp_d = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q   <= ST_IDLE;
      mode_q   <= MODE_READ;
      susp_q   <= 1'b0;
      pgm_q    <= 1'b0;
      chip_q   <= 1'b0;
      sect_q   <= 1'b0;
      sus_q    <= 1'b0;
      res_q    <= 1'b0;
      paddr_q  <= '0;
      pdata_q  <= '0;
      sector_q <= '0;
    end else begin
      step_q <= step_d;
      mode_q <= mode_d;
      susp_q <= susp_d;
      pgm_q  <= pgm_d;
      chip_q <= chip_d;
      sect_q <= sect_d;
      sus_q  <= sus_d;
      res_q  <= res_d;
      if (pgm_d) begin
        paddr_q <= wr_addr_i;
        pdata_q <= wr_data_i;
      end
      if (sect_d) sector_q <= sector_i;
    end
  end

  assign mode_o         = mode_q;
  assign suspended_o    = susp_q;
  assign prog_req_o     = pgm_q;
  assign prog_addr_o    = paddr_q;
  assign prog_data_o    = pdata_q;
  assign chip_erase_o   = chip_q;
  assign sector_erase_o = sect_q;
  assign sector_o       = sector_q;
  assign suspend_o      = sus_q;
  assign resume_o       = res_q;
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
  parameter int unsigned ADDR_W   = 20,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned SECT_LSB = 12,
  parameter int unsigned SECT_W   = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              byte_mode_i,
  input  logic              erase_busy_i,
  output logic [1:0]        mode_o,
  output logic              suspended_o,
  output logic              prog_req_o,
  output logic [ADDR_W-1:0] prog_addr_o,
  output logic [DATA_W-1:0] prog_data_o,
  output logic              chip_erase_o,
  output logic              sector_erase_o,
  output logic [SECT_W-1:0] sector_o,
  output logic              suspend_o,
  output logic              resume_o
);
  logic              key_a, key_b;
  logic [7:0]        code;
  logic [SECT_W-1:0] sector_raw;

  flash_cmd_decode #(
    .ADDR_W  (ADDR_W),
    .SECT_LSB(SECT_LSB),
    .SECT_W  (SECT_W)
  ) u_decode (
    .addr_i     (wr_addr_i),
    .code_i     (wr_data_i[7:0]),
    .byte_mode_i(byte_mode_i),
    .key_a_o    (key_a),
    .key_b_o    (key_b),
    .code_o     (code),
    .sector_o   (sector_raw)
  );

  flash_cmd_fsm #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .SECT_W(SECT_W)
  ) u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_valid_i    (wr_valid_i),
    .wr_addr_i     (wr_addr_i),
    .wr_data_i     (wr_data_i),
    .erase_busy_i  (erase_busy_i),
    .key_a_i       (key_a),
    .key_b_i       (key_b),
    .code_i        (code),
    .sector_i      (sector_raw),
    .mode_o        (mode_o),
    .suspended_o   (suspended_o),
    .prog_req_o    (prog_req_o),
    .prog_addr_o   (prog_addr_o),
    .prog_data_o   (prog_data_o),
    .chip_erase_o  (chip_erase_o),
    .sector_erase_o(sector_erase_o),
    .sector_o      (sector_o),
    .suspend_o     (suspend_o),
    .resume_o      (resume_o)
  );
endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk #(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned SECT_W = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_valid_i,
  input logic              erase_busy_i,
  input logic [1:0]        mode_o,
  input logic              suspended_o,
  input logic              prog_req_o,
  input logic [ADDR_W-1:0] prog_addr_o,
  input logic              chip_erase_o,
  input logic              sector_erase_o,
  input logic [SECT_W-1:0] sector_o,
  input logic              suspend_o,
  input logic              resume_o
);
  logic any_req;
  assign any_req = prog_req_o | chip_erase_o | sector_erase_o | suspend_o | resume_o;

  a_r13_single_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({prog_req_o, chip_erase_o, sector_erase_o, suspend_o, resume_o}));

  a_r13_prog_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_req_o |=> !prog_req_o);

  a_r13_erase_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chip_erase_o | sector_erase_o) |=> !(chip_erase_o | sector_erase_o));

  a_r11_req_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_req |-> $past(wr_valid_i));

  a_r11_mode_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mode_o) |-> $past(wr_valid_i));

  a_r1_mode_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o != 2'b11);

  a_r9_suspend_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    suspend_o |-> (suspended_o && $past(erase_busy_i) && !$past(suspended_o)));

  a_r9_resume_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_o |-> (!suspended_o && $past(suspended_o)));

  a_r10_no_erase_suspended: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chip_erase_o | sector_erase_o) |-> !$past(suspended_o));

  a_r5_sector_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sector_o) |-> sector_erase_o);

  a_r3_addr_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(prog_addr_o) |-> prog_req_o);
endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk #(
  .ADDR_W(ADDR_W),
  .SECT_W(SECT_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .wr_valid_i    (wr_valid_i),
  .erase_busy_i  (erase_busy_i),
  .mode_o        (mode_o),
  .suspended_o   (suspended_o),
  .prog_req_o    (prog_req_o),
  .prog_addr_o   (prog_addr_o),
  .chip_erase_o  (chip_erase_o),
  .sector_erase_o(sector_erase_o),
  .sector_o      (sector_o),
  .suspend_o     (suspend_o),
  .resume_o      (resume_o)
);

// File: tb/flash_cmd_decoder_test.sv
module flash_cmd_decoder_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_valid = 1'b0;
  logic [19:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        byte_mode = 1'b0;
  logic        busy = 1'b0;
  logic [1:0]  mode;
  logic        susp, preq, cer, ser, sus, res;
  logic [19:0] paddr;
  logic [15:0] pdata;
  logic [6:0]  sect;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  flash_cmd_decoder uut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_valid_i(wr_valid), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .byte_mode_i(byte_mode), .erase_busy_i(busy),
    .mode_o(mode), .suspended_o(susp), .prog_req_o(preq), .prog_addr_o(paddr),
    .prog_data_o(pdata), .chip_erase_o(cer), .sector_erase_o(ser),
    .sector_o(sect), .suspend_o(sus), .resume_o(res)
  );

  // {rid[4], byte, addr[20], data[16], busy, exp_mode[2], exp_susp, exp_req[5]}
  // exp_req order: {prog, chip, sector, suspend, resume}
  localparam int NV = 63;
  localparam logic [49:0] VEC [0:NV-1] = '{
    // R2 word keys into autoselect
    {4'd2,1'b0,20'h00555,16'h00AA,1'b0,2'd0,1'b0,5'b00000},
    {4'd2,1'b0,20'h002AA,16'h0055,1'b0,2'd0,1'b0,5'b00000},
    {4'd2,1'b0,20'h00555,16'h0090,1'b0,2'd1,1'b0,5'b00000},
    // R6 autoselect ignores others, F0 leaves
    {4'd6,1'b0,20'h00555,16'h00AA,1'b0,2'd1,1'b0,5'b00000},
    {4'd6,1'b0,20'h12345,16'h00F0,1'b0,2'd0,1'b0,5'b00000},
    // R2 byte keys
    {4'd2,1'b1,20'h00AAA,16'h00AA,1'b0,2'd0,1'b0,5'b00000},
    {4'd2,1'b1,20'h00555,16'h0055,1'b0,2'd0,1'b0,5'b00000},
    {4'd2,1'b1,20'h00AAA,16'h0090,1'b0,2'd1,1'b0,5'b00000},
    {4'd6,1'b0,20'h7FFFF,16'h00F0,1'b0,2'd0,1'b0,5'b00000},
    // R3 program
    {4'd3,1'b0,20'h00555,16'h00AA,1'b0,2'd0,1'b0,5'b00000},
    {4'd3,1'b0,20'h002AA,16'h0055,1'b0,2'd0,1'b0,5'b00000},
    {4'd3,1'b0,20'h00555,16'h00A0,1'b0,2'd0,1'b0,5'b00000},
    {4'd3,1'b0,20'h01234,16'hBEEF,1'b0,2'd0,1'b0,5'b10000},
    // R4 chip erase
    {4'd4,1'b0,20'h00555,16'h00AA,1'b0,2'd0,1'b0,5'b00000},
    {4'd4,1'b0,20'h002AA,16'h0055,1'b0,2'd0,1'b0,5'b00000},
    {4'd4,1'b0,20'h00555,16'h0080,1'b0,2'd0,1'b0,5'b00000},
    {4'd4,1'b0,20'h00555,16'h00AA,1'b0,2'd0,1'b0,5'b00000},
    {4'd4,1'b0,20'h002AA,16'h0055,1'b0,2'd0,1'b0,5'b00000},
    {4'd4,1'b0,20'h00555,16'h0010,1'b0,2'd0,1'b0,5'b01000},
    // R5 sector erase
    {4'd5,1'b0,20'h00555,16'h00AA,1'b0,2'd0,1'b0,5'b00000},
    {4'd5,1'b0,20'h002AA,16'h0055,1'b0,2'd0,1'b0,5'b00000},
    {4'd5,1'b0,20'h00555,16'h0080,1'b0,2'd0,1'b0,5'b00000},
    {4'd5,1'b0,20'h00555,16'h00AA,1'b0,2'd0,1'b0,5'b00000},
    {4'd5,1'b0,20'h002AA,16'h0055,1'b0,2'd0,1'b0,5'b00000},
    {4'd5,1'b0,20'h35000,16'h0030,1'b0,2'd0,1'b0,5'b00100},
    // R9 suspend / resume gating
    {4'd9,1'b0,20'h00000,16'h00B0,1'b1,2'd0,1'b1,5'b00010},
    {4'd9,1'b0,20'h00000,16'h00B0,1'b1,2'd0,1'b1,5'b00000},
    {4'd9,1'b0,20'h00000,16'h0030,1'b0,2'd0,1'b0,5'b00001},
    {4'd9,1'b0,20'h00000,16'h00B0,1'b0,2'd0,1'b0,5'b00000},
    {4'd9,1'b0,20'h00000,16'h0030,1'b0,2'd0,1'b0,5'b00000},
    // R11 mismatches drop sequences
    {4'd11,1'b0,20'h00555,16'h00AA,1'b0,2'd0,1'b0,5'b00000},
    {4'd11,1'b0,20'h002AA,16'h0012,1'b0,2'd0,1'b0,5'b00000},
    {4'd11,1'b0,20'h00555,16'h00A0,1'b0,2'd0,1'b0,5'b00000},
    {4'd11,1'b0,20'h00000,16'h1234,1'b0,2'd0,1'b0,5'b00000},
    {4'd11,1'b0,20'h00555,16'h00AA,1'b0,2'd0,1'b0,5'b00000},
    {4'd11,1'b0,20'h002AA,16'h0055,1'b0,2'd0,1'b0,5'b00000},
    {4'd11,1'b0,20'h00555,16'h0080,1'b0,2'd0,1'b0,5'b00000},
    {4'd11,1'b0,20'h00555,16'h00AA,1'b0,2'd0,1'b0,5'b00000},
    {4'd11,1'b0,20'h00555,16'h0055,1'b0,2'd0,1'b0,5'b00000},
    {4'd11,1'b0,20'h00555,16'h0010,1'b0,2'd0,1'b0,5'b00000},
    // R12 high bits masked, entering bypass (R7)
    {4'd12,1'b0,20'hFF555,16'h12AA,1'b0,2'd0,1'b0,5'b00000},
    {4'd12,1'b0,20'h7F2AA,16'h3455,1'b0,2'd0,1'b0,5'b00000},
    {4'd12,1'b0,20'h80555,16'hFF20,1'b0,2'd2,1'b0,5'b00000},
    // R7 bypass program
    {4'd7,1'b0,20'h0ABCD,16'h00A0,1'b0,2'd2,1'b0,5'b00000},
    {4'd7,1'b0,20'h00042,16'h1111,1'b0,2'd2,1'b0,5'b10000},
    // R8 bypass exit
    {4'd8,1'b0,20'h12345,16'h0090,1'b0,2'd2,1'b0,5'b00000},
    {4'd8,1'b0,20'h00000,16'h0000,1'b0,2'd0,1'b0,5'b00000},
    // R10 suspended rules
    {4'd10,1'b0,20'h00000,16'h00B0,1'b1,2'd0,1'b1,5'b00010},
    {4'd10,1'b0,20'h00555,16'h00AA,1'b1,2'd0,1'b1,5'b00000},
    {4'd10,1'b0,20'h002AA,16'h0055,1'b1,2'd0,1'b1,5'b00000},
    {4'd10,1'b0,20'h00555,16'h0080,1'b1,2'd0,1'b1,5'b00000},
    {4'd10,1'b0,20'h00555,16'h00AA,1'b1,2'd0,1'b1,5'b00000},
    {4'd10,1'b0,20'h002AA,16'h0055,1'b1,2'd0,1'b1,5'b00000},
    {4'd10,1'b0,20'h00555,16'h00A0,1'b1,2'd0,1'b1,5'b00000},
    {4'd10,1'b0,20'h00100,16'h5555,1'b1,2'd0,1'b1,5'b10000},
    {4'd10,1'b0,20'h00555,16'h00AA,1'b1,2'd0,1'b1,5'b00000},
    {4'd10,1'b0,20'h002AA,16'h0055,1'b1,2'd0,1'b1,5'b00000},
    {4'd10,1'b0,20'h00555,16'h0020,1'b1,2'd0,1'b1,5'b00000},
    {4'd10,1'b0,20'h00555,16'h00AA,1'b1,2'd0,1'b1,5'b00000},
    {4'd10,1'b0,20'h002AA,16'h0055,1'b1,2'd0,1'b1,5'b00000},
    {4'd10,1'b0,20'h00555,16'h0090,1'b1,2'd1,1'b1,5'b00000},
    {4'd10,1'b0,20'h00000,16'h0030,1'b1,2'd1,1'b0,5'b00001},
    {4'd10,1'b0,20'h00000,16'h00F0,1'b1,2'd0,1'b0,5'b00000}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic b, input logic [19:0] a, input logic [15:0] d, input logic bz);
    @(negedge clk);
    byte_mode = b;
    wr_addr   = a;
    wr_data   = d;
    busy      = bz;
    wr_valid  = 1'b1;
    @(negedge clk);
    wr_valid  = 1'b0;
  endtask

  task automatic pulse_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  function automatic logic [4:0] reqs();
    return {preq, cer, ser, sus, res};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 mode in reset", {30'd0, mode}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 flags after reset", {26'd0, susp, reqs()}, 32'd0);
    check("R1 prog addr after reset", {12'd0, paddr}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [49:0] v;
      v = VEC[i];
      wr(v[45], v[44:25], v[24:9], v[8]);
      check($sformatf("R%0d vec %0d", v[49:46], i),
            {24'd0, mode, susp, reqs()}, {24'd0, v[7:0]});
    end

    // R3 captured address and data, R13 one-cycle pulse
    wr(1'b0, 20'h00555, 16'h00AA, 1'b0);
    wr(1'b0, 20'h002AA, 16'h0055, 1'b0);
    wr(1'b0, 20'h00555, 16'h00A0, 1'b0);
    wr(1'b0, 20'h5A5A5, 16'hC3C3, 1'b0);
    check("R3 prog addr", {12'd0, paddr}, 32'h5A5A5);
    check("R3 prog data", {16'd0, pdata}, 32'hC3C3);
    @(negedge clk);
    check("R13 prog pulse width", {27'd0, reqs()}, 32'd0);

    // R5 sector field, word then byte addressing
    wr(1'b0, 20'h00555, 16'h00AA, 1'b0);
    wr(1'b0, 20'h002AA, 16'h0055, 1'b0);
    wr(1'b0, 20'h00555, 16'h0080, 1'b0);
    wr(1'b0, 20'h00555, 16'h00AA, 1'b0);
    wr(1'b0, 20'h002AA, 16'h0055, 1'b0);
    wr(1'b0, 20'h35ABC, 16'h0030, 1'b0);
    check("R5 word sector", {25'd0, sect}, 32'h35);
    wr(1'b1, 20'h00AAA, 16'h00AA, 1'b0);
    wr(1'b1, 20'h00555, 16'h0055, 1'b0);
    wr(1'b1, 20'h00AAA, 16'h0080, 1'b0);
    wr(1'b1, 20'h00AAA, 16'h00AA, 1'b0);
    wr(1'b1, 20'h00555, 16'h0055, 1'b0);
    wr(1'b1, 20'hAB000, 16'h0030, 1'b0);
    check("R5 byte sector pulse", {27'd0, reqs()}, 32'b00100);
    check("R5 byte sector", {25'd0, sect}, 32'h55);
    wr(1'b0, 20'h00000, 16'h0030, 1'b0);
    check("R5 sector held", {25'd0, sect}, 32'h55);

    // R1 reset leaves bypass
    wr(1'b0, 20'h00555, 16'h00AA, 1'b0);
    wr(1'b0, 20'h002AA, 16'h0055, 1'b0);
    wr(1'b0, 20'h00555, 16'h0020, 1'b0);
    check("R7 bypass entered", {30'd0, mode}, 32'd2);
    pulse_reset();
    check("R1 reset exits bypass", {30'd0, mode}, 32'd0);

    // R1 reset drops a partial unlock
    wr(1'b0, 20'h00555, 16'h00AA, 1'b0);
    wr(1'b0, 20'h002AA, 16'h0055, 1'b0);
    pulse_reset();
    wr(1'b0, 20'h00555, 16'h00A0, 1'b0);
    wr(1'b0, 20'h00000, 16'h1234, 1'b0);
    check("R1 partial dropped by reset", {27'd0, reqs()}, 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule